// File: doc/BRIEF.md
# Sequential-Access Configuration Register Slave on a Two-Wire Serial Bus

This block is the configuration port of a clock-generation device. It listens on a two-wire serial bus (I2C, standard mode), answers to one fixed device address and holds a small bank of byte-wide control registers that it presents in parallel to the rest of the chip. The system clock oversamples both bus lines, and the block pulls the data line low through an open-drain enable output.

Access is always sequential and always starts at register 0. On a write, the first two bytes after the address are a command code and a byte count; the slave acknowledges both and discards them. Every later byte loads the next register. On a read, the slave first sends the register count and then the registers in ascending order. One register is reserved and cannot be changed. Four bits spread over three registers show the inverted levels that four strap inputs had during reset, and writes do not change them.

Top module: `cfgi2c_slave`

## Requirements
- R1: The slave acknowledges address byte 0xD2 (write) and 0xD3 (read), which is 7-bit address 0x69 followed by the direction bit. Any other address is not acknowledged, and the slave leaves SDA alone until the next start condition.
- R2: On a write, the two bytes after the address (command code, then byte count) are acknowledged and change no register.
- R3: Write data bytes that follow those two load registers 0, 1, 2 and up in that order, and each one is acknowledged.
- R4: A stop condition after any complete byte leaves every fully received byte written. A byte cut short by a stop is not written.
- R5: On a read, the slave sends the register count (7 with the default parameters) first and then registers 0, 1, 2 and up, for as long as the host acknowledges.
- R6: Write bytes beyond the last register are acknowledged and discarded. Read bytes beyond the last register return 0xFF.
- R7: After reset, register 0 is 0x00, register 6 is 0x06, and registers 1 to 5 are 0xFF in every bit that is not a strap bit.
- R8: Register 6 is reserved. Writes to it are acknowledged, and it keeps the value 0x06.
- R9: Strap bits read as the inverse of strap_i as sampled during reset: register 1 bit 7 = ~strap_i[2], register 3 bit 6 = ~strap_i[0], register 4 bit 3 = ~strap_i[1], register 4 bit 1 = ~strap_i[3]. Writes do not change them.
- R10: When the host does not acknowledge a read byte, the slave releases SDA and ignores the clock until the next start condition.
- R11: A repeated start in the middle of a transfer restarts address decoding, so a write can be followed directly by a read.
- R12: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset. The straps are sampled while it is low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 4 | Strap levels sampled during reset |
| sda_pull | output | 1 | When 1, the slave pulls SDA low |
| cfg_o | output | 8*NUM_REGS | Register bank; register n is on bits 8n+7 down to 8n |

## Verification
The bench targets the points where a sequential-access slave usually goes wrong. It checks that the two discarded header bytes do not shift the data into register 0 or 1: a design that counted them would place every byte one or two registers too high. It checks that a stop in the middle of a byte does not commit the partial byte, which a design that wrote on every bit would do. It checks that the reserved byte and the strap bits survive writes that cover them, and that 0xFF appears past the end of a read. After a host NACK, it keeps clocking the bus to show that the slave has released SDA; a slave that kept shifting data would corrupt the line. It also issues a repeated start straight after a write to show that address decoding starts again.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WRX,
      ST_WACK,
      ST_RTX,
      ST_RACK
   } bus_state_e;

   localparam int STRAP_W = 4;

   // bits of a register that mirror a strap rather than stored data
   function automatic logic [7:0] strap_mask(input int idx);
      case (idx)
         1:       return 8'h80;
         3:       return 8'h40;
         4:       return 8'h0A;
         default: return 8'h00;
      endcase
   endfunction

   // inverted strap levels placed at their bit positions
   function automatic logic [7:0] strap_fill(input int idx, input logic [STRAP_W-1:0] s);
      case (idx)
         1:       return {~s[2], 7'b0};
         3:       return {1'b0, ~s[0], 6'b0};
         4:       return {4'b0, ~s[1], 1'b0, ~s[3], 1'b0};
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] reset_byte(input int idx, input int res_idx);
      if (idx == 0)            return 8'h00;
      else if (idx == res_idx) return 8'h06;
      else                     return 8'hFF;
   endfunction

endpackage

// File: rtl/cfgi2c_sync.sv
module cfgi2c_sync #(
   parameter int   W       = 2,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cfgi2c_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < W; g++) begin : g_lane
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= {STAGES{RST_VAL}};
         else        pipe <= {pipe[STAGES-2:0], d[g]};
      end
      assign q[g] = pipe[STAGES-1];
   end

endmodule

// File: rtl/cfgi2c_linecond.sv
module cfgi2c_linecond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_c,
   output logic stop_c,
   output logic sda_lvl
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
   assign sda_lvl  = sda_s;

endmodule

// File: rtl/cfgi2c_regfile.sv
module cfgi2c_regfile
   import cfgi2c_pkg::*;
#(
   parameter int NUM_REGS = 7,
   parameter int RES_IDX  = 6,
   parameter int IDXW     = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [STRAP_W-1:0]    strap_i,
   input  logic                  wr_en,
   input  logic [IDXW-1:0]       wr_idx,
   input  logic [7:0]            wr_data,
   input  logic [IDXW-1:0]       rd_idx,
   output logic [7:0]            rd_data,
   output logic [NUM_REGS*8-1:0] cfg_o
);

   logic [STRAP_W-1:0] strap_q;
   logic [7:0]         bytes_w [NUM_REGS];

   // straps follow the pins for as long as reset is held, then freeze
   always_ff @(posedge clk) begin
      if (!rst_n) strap_q <= strap_i;
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      if (g == RES_IDX) begin : g_locked
         assign bytes_w[g] = reset_byte(g, RES_IDX);
      end else begin : g_store
         localparam logic [7:0] MASK = strap_mask(g);
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= reset_byte(g, RES_IDX);
            else if (wr_en && wr_idx == IDXW'(g))
               q <= wr_data;
         end
         assign bytes_w[g] = (q & ~MASK) | (strap_fill(g, strap_q) & MASK);
      end
      assign cfg_o[g*8 +: 8] = bytes_w[g];
   end

   always_comb begin
      rd_data = 8'hFF;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_idx == IDXW'(i)) rd_data = bytes_w[i];
      end
   end

endmodule

// File: rtl/cfgi2c_engine.sv
module cfgi2c_engine
   import cfgi2c_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h69,
   parameter int         NUM_REGS = 7,
   parameter int         SEQW     = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_rise,
   input  logic            scl_fall,
   input  logic            start_c,
   input  logic            stop_c,
   input  logic            sda_lvl,
   input  logic [7:0]      rd_data,
   output logic [SEQW-1:0] rd_idx,
   output logic            wr_en,
   output logic [SEQW-1:0] wr_idx,
   output logic [7:0]      wr_data,
   output logic            sda_pull
);

   localparam logic [7:0]      COUNT_BYTE = 8'(NUM_REGS);
   localparam logic [SEQW-1:0] SEQ_MAX    = '1;

   bus_state_e      state;
   logic [3:0]      bitcnt;
   logic [7:0]      shreg;
   logic            is_read;
   logic            host_ack;
   logic [SEQW-1:0] seq;
   logic [SEQW-1:0] seq_inc;
   logic [7:0]      tx_byte;

   // position in the transfer: 0 = first byte after the address
   assign seq_inc = (seq == SEQ_MAX) ? seq : seq + SEQW'(1);
   assign rd_idx  = seq - SEQW'(1);
   assign tx_byte = (seq == '0) ? COUNT_BYTE : rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         is_read  <= 1'b0;
         host_ack <= 1'b0;
         seq      <= '0;
         sda_pull <= 1'b0;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_c) begin
            state    <= ST_ADDR;
            bitcnt   <= '0;
            seq      <= '0;
            sda_pull <= 1'b0;
         end else if (stop_c) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: ;
               ST_ADDR, ST_WRX: begin
                  if (scl_rise && bitcnt != 4'd8) begin
                     shreg  <= {shreg[6:0], sda_lvl};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     if (state == ST_ADDR) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                           is_read  <= shreg[0];
                           sda_pull <= 1'b1;
                           state    <= ST_AACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else begin
                        if (seq >= SEQW'(2)) begin
                           wr_en   <= 1'b1;
                           wr_idx  <= seq - SEQW'(2);
                           wr_data <= shreg;
                        end
                        seq      <= seq_inc;
                        sda_pull <= 1'b1;
                        state    <= ST_WACK;
                     end
                  end
               end
               ST_AACK, ST_WACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (state == ST_AACK && is_read) begin
                        shreg    <= tx_byte;
                        sda_pull <= ~tx_byte[7];
                        seq      <= seq_inc;
                        state    <= ST_RTX;
                     end else begin
                        sda_pull <= 1'b0;
                        state    <= ST_WRX;
                     end
                  end
               end
               ST_RTX: begin
                  if (scl_fall) begin
                     if (bitcnt == 4'd7) begin
                        sda_pull <= 1'b0;
                        state    <= ST_RACK;
                     end else begin
                        bitcnt   <= bitcnt + 4'd1;
                        sda_pull <= ~shreg[6];
                        shreg    <= {shreg[6:0], 1'b0};
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     host_ack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (host_ack) begin
                        bitcnt   <= '0;
                        shreg    <= tx_byte;
                        sda_pull <= ~tx_byte[7];
                        seq      <= seq_inc;
                        state    <= ST_RTX;
                     end else begin
                        sda_pull <= 1'b0;
                        state    <= ST_IDLE;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/cfgi2c_slave.sv
module cfgi2c_slave
   import cfgi2c_pkg::*;
#(
   parameter int         NUM_REGS     = 7,
   parameter logic [6:0] DEV_ADDR     = 7'h69,
   parameter int         SYNC_STAGES  = 2,
   parameter int         RESERVED_IDX = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   input  logic [3:0]            strap_i,
   output logic                  sda_pull,
   output logic [NUM_REGS*8-1:0] cfg_o
);

   localparam int SEQW = $clog2(NUM_REGS + 3);

   if (NUM_REGS < 7 || NUM_REGS > 250) begin : g_bad_regs
      $error("cfgi2c_slave: NUM_REGS must be 7..250");
   end
   if (RESERVED_IDX >= NUM_REGS) begin : g_bad_res
      $error("cfgi2c_slave: RESERVED_IDX out of range");
   end

   logic [1:0]      lines_s;
   logic            scl_rise, scl_fall, start_c, stop_c, sda_lvl;
   logic [SEQW-1:0] rd_idx, wr_idx;
   logic [7:0]      rd_data, wr_data;
   logic            wr_en;

   cfgi2c_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (lines_s)
   );

   cfgi2c_linecond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (lines_s[1]),
      .sda_s    (lines_s[0]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_c  (start_c),
      .stop_c   (stop_c),
      .sda_lvl  (sda_lvl)
   );

   cfgi2c_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .SEQW(SEQW)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_c  (start_c),
      .stop_c   (stop_c),
      .sda_lvl  (sda_lvl),
      .rd_data  (rd_data),
      .rd_idx   (rd_idx),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .sda_pull (sda_pull)
   );

   cfgi2c_regfile #(.NUM_REGS(NUM_REGS), .RES_IDX(RESERVED_IDX), .IDXW(SEQW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap_i (strap_i),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .cfg_o   (cfg_o)
   );

endmodule

// File: rtl/cfgi2c_slave_chk.sv
module cfgi2c_slave_chk #(
   parameter int NUM_REGS = 7,
   parameter int RES_IDX  = 6
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  scl_i,
   input logic                  sda_pull,
   input logic [NUM_REGS*8-1:0] cfg_o
);

   // R12: data drive only moves while the clock line is low
   assert_drive_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull != $past(sda_pull)) |-> !scl_i);

   // R3: register contents only change during the low phase (ack slot)
   assert_commit_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_o != $past(cfg_o)) |-> !scl_i);

   // R8: reserved byte never moves once out of reset
   assert_reserved_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(cfg_o[RES_IDX*8 +: 8]));

   // R9: strap bits frozen after reset
   assert_strap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $stable({cfg_o[15], cfg_o[30], cfg_o[35], cfg_o[33]}));

endmodule

bind cfgi2c_slave cfgi2c_slave_chk #(.NUM_REGS(NUM_REGS), .RES_IDX(RESERVED_IDX)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_i    (scl_i),
   .sda_pull (sda_pull),
   .cfg_o    (cfg_o)
);

// File: tb/tb_cfgi2c_slave.sv
module tb_cfgi2c_slave;

   localparam int NREG = 7;
   localparam int Q    = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             scl = 1'b1;
   logic             host_pull = 1'b0;
   logic [3:0]       strap = 4'b0101;
   logic             dut_pull;
   logic [NREG*8-1:0] cfg;
   wire              sda_line = ~(dut_pull | host_pull);

   int checks = 0;
   int fails  = 0;
   int r12_viol = 0;
   logic [7:0] exp_r [NREG];
   logic [7:0] wbuf [16];

   always #4 clk = ~clk;

   cfgi2c_slave dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl),
      .sda_i    (sda_line),
      .strap_i  (strap),
      .sda_pull (dut_pull),
      .cfg_o    (cfg)
   );

   function automatic logic [7:0] smask(input int i);
      if (i == 1) return 8'h80;
      if (i == 3) return 8'h40;
      if (i == 4) return 8'h0A;
      return 8'h00;
   endfunction

   function automatic logic [7:0] tb_default(input int i, input logic [3:0] s);
      case (i)
         0: return 8'h00;
         1: return {~s[2], 7'h7F};
         3: return {1'b1, ~s[0], 6'h3F};
         4: return {4'hF, ~s[1], 1'b1, ~s[3], 1'b1};
         6: return 8'h06;
         default: return 8'hFF;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic model_reset();
      for (int i = 0; i < NREG; i++) exp_r[i] = tb_default(i, strap);
   endtask

   task automatic model_write(input int k, input logic [7:0] d);
      if (k < NREG && k != 6) exp_r[k] = (d & ~smask(k)) | (exp_r[k] & smask(k));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(6);
      rst_n = 1'b1;
      tick(4);
      model_reset();
   endtask

   task automatic bus_start();
      host_pull = 1'b1; tick(Q);
      scl = 1'b0;       tick(Q);
   endtask

   task automatic bus_rstart();
      host_pull = 1'b0; tick(Q);
      scl = 1'b1;       tick(Q);
      host_pull = 1'b1; tick(Q);
      scl = 1'b0;       tick(Q);
   endtask

   task automatic bus_stop();
      host_pull = 1'b1; tick(Q);
      scl = 1'b1;       tick(Q);
      host_pull = 1'b0; tick(2*Q);
   endtask

   task automatic send_bit(input logic b);
      host_pull = ~b; tick(Q);
      scl = 1'b1;     tick(2*Q);
      scl = 1'b0;     tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      host_pull = 1'b0; tick(Q);
      scl = 1'b1;       tick(Q);
      acked = ~sda_line;
      tick(Q);
      scl = 1'b0;       tick(Q);
   endtask

   task automatic recv_byte(output logic [7:0] b, input bit ack);
      host_pull = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         scl = 1'b1; tick(Q);
         b[i] = sda_line;
         tick(Q);
         scl = 1'b0;
      end
      tick(Q);
      host_pull = ack; tick(Q);
      scl = 1'b1;      tick(2*Q);
      scl = 1'b0;      tick(Q);
      host_pull = 1'b0;
   endtask

   task automatic check_regs(input string req);
      for (int i = 0; i < NREG; i++)
         chk(cfg[i*8 +: 8] == exp_r[i], req, cfg[i*8 +: 8], exp_r[i]);
   endtask

   // write n data bytes from wbuf after the two discarded header bytes
   task automatic wr_xfer(input int n, input logic [7:0] cmd, input logic [7:0] cnt, output int nacks);
      bit a;
      nacks = 0;
      bus_start();
      send_byte(8'hD2, a); if (!a) nacks++;
      send_byte(cmd, a);   if (!a) nacks++;
      send_byte(cnt, a);   if (!a) nacks++;
      for (int k = 0; k < n; k++) begin
         send_byte(wbuf[k], a);
         if (!a) nacks++;
         model_write(k, wbuf[k]);
      end
      bus_stop();
   endtask

   // full read: count, every register, one byte past the end
   task automatic rd_check(input string req);
      bit a;
      logic [7:0] b;
      bus_start();
      send_byte(8'hD3, a);
      chk(a, {req, " R1 read address ack"}, a, 1);
      recv_byte(b, 1'b1);
      chk(b == 8'(NREG), {req, " R5 count byte"}, b, NREG);
      for (int i = 0; i < NREG; i++) begin
         recv_byte(b, 1'b1);
         chk(b == exp_r[i], {req, " R5 register byte"}, b, exp_r[i]);
      end
      recv_byte(b, 1'b0);
      chk(b == 8'hFF, {req, " R6 read past end"}, b, 8'hFF);
      bus_stop();
   endtask

   always @(negedge clk) begin : r12_mon
      logic prev;
      if (rst_n && scl && dut_pull !== prev) r12_viol++;
      prev = dut_pull;
   end

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      bit a;
      int nk;
      logic [7:0] b;
      void'($urandom(32'h1A2B3C4D));

      do_reset();
      // R7 R9 reset state with straps 0101
      check_regs("R7 R9 reset defaults");

      // R1 foreign address: no ack, slave silent on the next byte
      bus_start();
      send_byte(8'hA4, a);
      chk(!a, "R1 foreign address nack", a, 0);
      send_byte(8'h00, a);
      chk(!a, "R1 silent after foreign address", a, 0);
      bus_stop();
      check_regs("R1 no change after foreign address");

      // R2 header bytes only
      wr_xfer(0, 8'h55, 8'h33, nk);
      chk(nk == 0, "R2 header bytes acked", nk, 0);
      check_regs("R2 header bytes discarded");

      // R3 sequential load
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      wr_xfer(3, 8'h00, 8'h03, nk);
      chk(nk == 0, "R3 data bytes acked", nk, 0);
      chk(cfg[7:0] == 8'h11, "R3 register 0 loaded", cfg[7:0], 8'h11);
      check_regs("R3 sequential load");

      // R4 stop after a partial byte
      bus_start();
      send_byte(8'hD2, a); send_byte(8'hEE, a); send_byte(8'h01, a);
      send_byte(8'hA5, a); model_write(0, 8'hA5);
      send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
      bus_stop();
      chk(cfg[7:0] == 8'hA5, "R4 complete byte kept", cfg[7:0], 8'hA5);
      chk(cfg[15:8] == exp_r[1], "R4 partial byte dropped", cfg[15:8], exp_r[1]);

      // R6 R8 R9 overlong write of zeros
      for (int k = 0; k < 10; k++) wbuf[k] = 8'h00;
      wr_xfer(10, 8'h00, 8'h0A, nk);
      chk(nk == 0, "R6 bytes past end acked", nk, 0);
      chk(cfg[55:48] == 8'h06, "R8 reserved byte kept", cfg[55:48], 8'h06);
      chk(cfg[15] == ~strap[2] && cfg[30] == ~strap[0], "R9 strap bits survive write",
          {cfg[15], cfg[30]}, {~strap[2], ~strap[0]});
      check_regs("R6 R8 R9 overlong write");

      // R5 R6 read back
      rd_check("R5");

      // R10 release after nack
      bus_start();
      send_byte(8'hD3, a);
      recv_byte(b, 1'b1);
      recv_byte(b, 1'b0);
      nk = 0;
      for (int i = 0; i < 9; i++) begin
         tick(Q); scl = 1'b1; tick(Q);
         if (!sda_line) nk++;
         tick(Q); scl = 1'b0; tick(Q);
      end
      chk(nk == 0, "R10 sda released after nack", nk, 0);
      bus_stop();

      // R11 write then repeated start into a read
      bus_start();
      send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
      send_byte(8'h3C, a); model_write(0, 8'h3C);
      bus_rstart();
      send_byte(8'hD3, a);
      chk(a, "R11 read address after repeated start", a, 1);
      recv_byte(b, 1'b1);
      chk(b == 8'(NREG), "R11 count after repeated start", b, NREG);
      recv_byte(b, 1'b0);
      chk(b == 8'h3C, "R11 register 0 after repeated start", b, 8'h3C);
      bus_stop();

      // random writes of random length, each followed by a full read (R3 R5 R6)
      for (int it = 0; it < 12; it++) begin
         int n;
         n = int'($urandom_range(0, 9));
         for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
         wr_xfer(n, 8'($urandom), 8'($urandom), nk);
         chk(nk == 0, "R3 random write acked", nk, 0);
         check_regs("R3 random write contents");
         if (it % 3 == 0) rd_check("R5 random");
      end

      // second strap pattern (R7 R9)
      strap = 4'b1010;
      do_reset();
      check_regs("R7 R9 reset defaults second strap");
      chk(cfg[35] == 1'b0 && cfg[33] == 1'b0, "R9 register 4 strap bits",
          {cfg[35], cfg[33]}, 2'b00);

      chk(r12_viol == 0, "R12 drive changed with scl high", r12_viol, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule